// File: doc/BRIEF.md
# UART Receive Buffer and Status Unit

This unit sits between a UART receive shift register and a processor-facing register port. Each time the shift register finishes a frame, it offers the data byte, the level sampled at the first stop bit and the received parity bit. The unit checks the parity, attaches error flags, and stores the result in a two-entry FIFO. When both FIFO slots are full, one more completed frame can wait in a holding register that stands for the shift register. If a further start bit arrives while all three places are taken, the waiting frame is lost and an overrun is recorded.

The error flags travel with each entry. Status outputs always show the flags of the oldest unread frame. A data read returns that frame and moves on to the next entry, so software reads status before data. A receive-done level and a level interrupt follow the FIFO occupancy. Dropping the receiver enable empties everything at once.

Top module: `uart_rx_buffer`

## Requirements
- R1: The FIFO holds two frames. A third completed frame waits in the holding register. On the clock edge of a data read it moves into the freed slot with its flags unchanged.
- R2: `rx_done` is 1 exactly when at least one unread frame is in the FIFO. It rises on the edge that accepts a frame.
- R3: `irq` equals `rx_done` AND `irq_en` and stays high for as long as both are high. The error flags never drive `irq`.
- R4: `err_frame`, `err_parity` and `err_overrun` show the flags stored with the oldest unread frame. A data read advances them to the next entry. All three read 0 when the FIFO is empty.
- R5: The frame error flag of an entry is 1 when its first stop bit was sampled as 0. It is 0 when that bit was 1.
- R6: The parity error flag of an entry is 1 only if `par_en` was 1 when the frame arrived and the parity does not match. With `par_odd`=0 the XOR of the data bits and the parity bit must be 0. With `par_odd`=1 it must be 1. With `par_en`=0 the flag is 0.
- R7: An overrun occurs when `start_det` pulses while the FIFO is full, a frame is waiting, and no data read happens in that cycle. The waiting frame is discarded. The next frame to enter the FIFO carries an overrun flag of 1. Frames entering after it carry 0.
- R8: While `rx_en` is 0, the next edge empties the FIFO and discards any waiting frame, and `rx_done` is 0. `frame_valid` and `start_det` are ignored.
- R9: A data read with the FIFO empty leaves `rd_byte` and all flags unchanged. After the last entry is read, `rd_byte` keeps the last byte that was read.
- R10: A synchronous active-high `rst` empties the FIFO and the holding register, clears all flags and sets `rd_byte` to 0.
- R11: A data read and an arriving frame in the same cycle both take effect. With one entry buffered, the FIFO then holds only the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes the unit |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| irq_en | input | 1 | Receive-done interrupt enable |
| frame_valid | input | 1 | One-cycle strobe: shift register finished a frame |
| frame_data | input | DATA_W | Received data bits |
| frame_stop | input | 1 | First stop bit as sampled |
| frame_par | input | 1 | Received parity bit |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd_pop | input | 1 | Data-location read strobe; pops the FIFO |
| rd_byte | output | DATA_W | Oldest unread byte, or last byte read when empty |
| rx_done | output | 1 | Unread data present |
| err_frame | output | 1 | Frame error of oldest unread frame |
| err_parity | output | 1 | Parity error of oldest unread frame |
| err_overrun | output | 1 | Overrun flag of oldest unread frame |
| irq | output | 1 | Level receive interrupt |

## Verification
A data read and a frame arrival can fall in the same cycle. This happens both when the FIFO holds a single entry and when it is full. In the full case, the waiting frame may also move into the slot the read frees. The bench raises `rd_pop` and `frame_valid` on the same edge and then reads the FIFO out. The order of the bytes and the flags each byte shows tell whether any frame was dropped, duplicated or reordered. The overrun case uses the same method: a read that moves the waiting frame must carry the overrun mark into the FIFO with that frame and on no other.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              ovr;
    } rxb_entry_t;
endpackage

// File: rtl/rxb_frame_check.sv
module rxb_frame_check
    import uart_rxb_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic              stop_bit,
    input  logic              par_bit,
    input  logic              par_en,
    input  logic              par_odd,
    output rxb_entry_t        entry
);
    always_comb begin
        entry.data = data;
        // only the first stop bit is looked at
        entry.ferr = ~stop_bit;
        // even: data^par must be 0, odd: must be 1
        entry.perr = par_en & ((^data) ^ par_bit ^ par_odd);
        entry.ovr  = 1'b0;
    end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  rxb_entry_t                   push_entry,
    input  logic                         pop,
    output rxb_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rxb_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CW-1:0]          cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic do_pop, do_push;
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != FULL_CNT) || do_pop);
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = push_entry;
                s_d.wp          = ptr_inc(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = ptr_inc(s_q.rp);
            end
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              irq_en,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_stop,
    input  logic              frame_par,
    input  logic              start_det,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rx_done,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rxb_entry_t        hold;
        logic              hold_v;
        logic              lost;
        logic [DATA_W-1:0] last;
    } ctl_st_t;

    ctl_st_t    c_d, c_q;
    rxb_entry_t new_entry, push_entry, head;
    logic       push, flush, pop_ok, full, space;
    logic [CW-1:0] count;

    rxb_frame_check u_check (
        .data     (frame_data),
        .stop_bit (frame_stop),
        .par_bit  (frame_par),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .entry    (new_entry)
    );

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop_ok),
        .head       (head),
        .count      (count)
    );

    assign full   = (count == FULL_CNT);
    assign pop_ok = rd_pop && (count != '0);
    assign space  = !full || pop_ok;

    always_comb begin
        c_d        = c_q;
        push       = 1'b0;
        flush      = 1'b0;
        push_entry = c_q.hold;
        if (!rx_en) begin
            flush    = 1'b1;
            c_d.hold_v = 1'b0;
            c_d.lost   = 1'b0;
        end else begin
            // a start bit with nowhere to go discards the waiting frame
            if (start_det && full && c_q.hold_v && !pop_ok) begin
                c_d.lost   = 1'b1;
                c_d.hold_v = 1'b0;
            end
            // waiting frame moves into a freed slot
            if (c_q.hold_v && space) begin
                push           = 1'b1;
                push_entry     = c_q.hold;
                push_entry.ovr = c_q.lost;
                c_d.hold_v     = 1'b0;
                c_d.lost       = 1'b0;
            end
            if (frame_valid) begin
                if (!push && space && !c_d.hold_v) begin
                    push           = 1'b1;
                    push_entry     = new_entry;
                    push_entry.ovr = c_d.lost;
                    c_d.lost       = 1'b0;
                end else begin
                    if (c_d.hold_v) c_d.lost = 1'b1;
                    c_d.hold   = new_entry;
                    c_d.hold_v = 1'b1;
                end
            end
        end
        if (pop_ok) c_d.last = head.data;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign rx_done     = (count != '0);
    assign rd_byte     = rx_done ? head.data : c_q.last;
    assign err_frame   = rx_done & head.ferr;
    assign err_parity  = rx_done & head.perr;
    assign err_overrun = rx_done & head.ovr;
    assign irq         = rx_done & irq_en;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk
    import uart_rxb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              irq_en,
    input logic              frame_valid,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_byte,
    input logic              rx_done,
    input logic              err_frame,
    input logic              err_parity,
    input logic              err_overrun,
    input logic              irq
);
    assert_irq_needs_done_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_done && irq_en));

    assert_disable_flushes_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_done);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!rx_done && !err_frame && !err_parity && !err_overrun && rd_byte == '0));

    assert_empty_read_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !rx_done && !frame_valid) |=> ($stable(rd_byte) && !rx_done));

    assert_no_flags_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> (!err_frame && !err_parity && !err_overrun));
endmodule

bind uart_rx_buffer uart_rx_buffer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .irq_en      (irq_en),
    .frame_valid (frame_valid),
    .rd_pop      (rd_pop),
    .rd_byte     (rd_byte),
    .rx_done     (rx_done),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .irq         (irq)
);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    logic       clk = 1'b0;
    logic       rst, rx_en, par_en, par_odd, irq_en;
    logic       frame_valid, frame_stop, frame_par, start_det, rd_pop;
    logic [7:0] frame_data, rd_byte;
    logic       rx_done, err_frame, err_parity, err_overrun, irq;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
        .irq_en(irq_en), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_stop(frame_stop), .frame_par(frame_par), .start_det(start_det),
        .rd_pop(rd_pop), .rd_byte(rd_byte), .rx_done(rx_done), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun), .irq(irq)
    );

    // {data, stop, parbit, par_en, par_odd, exp_ferr, exp_perr}
    localparam logic [13:0] VEC [0:7] = '{
        {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] d, input logic stp, input logic pb);
        frame_valid = 1'b1; frame_data = d; frame_stop = stp; frame_par = pb;
        tick();
        frame_valid = 1'b0;
    endtask

    task automatic pop;
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; rx_en = 1'b1; par_en = 1'b0; par_odd = 1'b0; irq_en = 1'b0;
        frame_valid = 1'b0; frame_data = '0; frame_stop = 1'b1; frame_par = 1'b0;
        start_det = 1'b0; rd_pop = 1'b0;
        tick(); tick();
        rst = 1'b0;
        // R10 reset state
        chk("R10 reset rx_done", rx_done, 0);
        chk("R10 reset flags", {err_frame, err_parity, err_overrun}, 0);
        chk("R10 reset rd_byte", rd_byte, 0);

        // table: R5, R6, R2, R4
        for (int i = 0; i < 8; i++) begin
            par_en = VEC[i][3]; par_odd = VEC[i][2];
            send(VEC[i][13:6], VEC[i][5], VEC[i][4]);
            chk("R2 rx_done after frame", rx_done, 1);
            chk("R4 head byte", rd_byte, VEC[i][13:6]);
            chk("R5 frame error", err_frame, VEC[i][1]);
            chk("R6 parity error", err_parity, VEC[i][0]);
            pop();
            chk("R2 rx_done after read", rx_done, 0);
            chk("R9 last byte kept", rd_byte, VEC[i][13:6]);
        end
        par_en = 1'b0;

        // R1: hold register and move on pop, flags intact
        send(8'h11, 1, 0); send(8'h22, 1, 0); send(8'h33, 0, 0);
        chk("R1 head after three frames", rd_byte, 8'h11);
        pop();
        chk("R1 second byte", rd_byte, 8'h22);
        pop();
        chk("R1 waiting frame reached FIFO", rd_byte, 8'h33);
        chk("R1 waiting frame ferr kept", err_frame, 1);
        chk("R4 flags advance", err_overrun, 0);
        pop();
        chk("R1 empty after three reads", rx_done, 0);

        // R7: overrun
        send(8'h41, 1, 0); send(8'h42, 1, 0); send(8'h43, 1, 0);
        start_det = 1'b1; tick(); start_det = 1'b0;
        send(8'h44, 0, 0);
        pop();
        chk("R7 second byte not marked", {rd_byte, err_overrun}, {8'h42, 1'b0});
        pop();
        chk("R7 survivor byte", rd_byte, 8'h44);
        chk("R7 overrun flag on next entry", err_overrun, 1);
        chk("R4 ferr of survivor", err_frame, 1);
        pop();
        chk("R7 empty", rx_done, 0);
        send(8'h45, 1, 0);
        chk("R7 overrun cleared afterwards", {rd_byte, err_overrun}, {8'h45, 1'b0});
        pop();

        // R11: simultaneous read and arrival
        send(8'h66, 1, 0);
        rd_pop = 1'b1; send(8'h77, 1, 0); rd_pop = 1'b0;
        chk("R11 one entry swap", {rx_done, rd_byte}, {1'b1, 8'h77});
        pop();
        chk("R11 only one entry", rx_done, 0);
        send(8'h81, 1, 0); send(8'h82, 1, 0);
        rd_pop = 1'b1; send(8'h83, 1, 0); rd_pop = 1'b0;
        chk("R11 full swap head", rd_byte, 8'h82);
        pop();
        chk("R11 full swap next", rd_byte, 8'h83);
        pop();
        chk("R11 drained", rx_done, 0);

        // R9: empty read
        pop();
        chk("R9 empty read byte", rd_byte, 8'h83);
        chk("R9 empty read flags", {rx_done, err_frame, err_parity, err_overrun}, 0);

        // R3: interrupt level
        send(8'h90, 0, 0);
        chk("R3 irq off when disabled", irq, 0);
        irq_en = 1'b1; #1;
        chk("R3 irq level", irq, 1);
        tick(); tick();
        chk("R3 irq held", irq, 1);
        pop();
        chk("R3 irq drops with buffer", irq, 0);
        par_en = 1'b1; send(8'h01, 0, 0); par_en = 1'b0; pop();
        chk("R3 error flags no irq", irq, 0);
        irq_en = 1'b0;

        // R8: disable flush
        send(8'hA1, 1, 0); send(8'hA2, 1, 0); send(8'hA3, 1, 0);
        rx_en = 1'b0; tick();
        chk("R8 flushed", rx_done, 0);
        send(8'hA4, 1, 0);
        chk("R8 frames ignored while off", rx_done, 0);
        rx_en = 1'b1; tick();
        chk("R8 waiting frame discarded", rx_done, 0);
        send(8'hA5, 1, 0);
        chk("R8 receive after re-enable", {rx_done, rd_byte}, {1'b1, 8'hA5});

        // R10: reset with content
        send(8'hB1, 0, 0);
        do_reset();
        chk("R10 reset empties", {rx_done, err_frame, err_parity, err_overrun}, 0);
        chk("R10 reset rd_byte zero", rd_byte, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule